// File: doc/BRIEF.md
# Multi-Channel ADC Sequencer and Result Register Front End

This block sits between a CPU register bus and a successive-approximation analog converter with several inputs. Software picks a contiguous channel window and a repeat policy, then starts a pass either by writing the run bit or by letting an external trigger line set it. The block walks the channel window, asks the converter for one sample at a time, and places every sample in a single result register.

Each stored sample raises a "result ready" flag. Reading the result register lowers that flag. If a new sample lands while the flag is still up, the block writes over the older value and raises a sticky overrun flag, which software clears by writing 1 to it. Each flag can drive its own interrupt line through a separate enable bit.

There are two pass policies. In one-shot mode the run bit falls by itself after the last channel. In repeating mode the window wraps back to its first channel until software clears the run bit. Clearing the enable bit stops everything at once and blocks every trigger.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every readable register (control at address 0, setup at 1, flags at 2, result at 3) reads 0, both interrupt lines are low and no conversion request is issued. Control bits 2, 3, 6 and 7 always read 0.
- R2: A write to control (address 0) with bit 0 (enable) = 1 and bit 1 (run) = 1 starts a pass while idle. Control bit 1 then reads 1 for as long as the pass is active.
- R3: Setup bits [2:0] are the first channel and bits [5:3] are the last channel. A pass requests the channels in ascending order from first to last. When first is greater than last, only the first channel is converted.
- R4: When setup bit 6 = 0 (one-shot), the run bit clears after the last channel's result is stored, and no further conversion is requested.
- R5: When setup bit 6 = 1 (repeating), the pass wraps from the last channel back to the first and keeps going. Writing control with bit 1 = 0 stops it.
- R6: While the enable bit is 0, the run bit stays 0 and both the software trigger and the hardware trigger are ignored: no conversion is requested.
- R7: When setup bit 7 = 1, a pulse on hw_trig while enabled and idle sets the run bit and starts a pass.
- R8: Each accepted converter result is copied into the result register (address 3) and sets status bit 0. A read of address 3 clears status bit 0.
- R9: A result that arrives while status bit 0 is set still replaces the stored value and sets status bit 1. Status bit 1 stays set until software writes 1 to status bit 1 at address 2.
- R10: irq_done is high exactly when status bit 0 and control bit 4 are both set. irq_ovr is high exactly when status bit 1 and control bit 5 are both set.
- R11: Writes to the setup register (address 1) take effect only while the enable bit is 0. Otherwise they leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of the result register has a side effect) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| hw_trig | input | 1 | External start pulse |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_ch | output | CH_W | Channel to sample |
| conv_done | input | 1 | One-cycle strobe: result valid |
| conv_result | input | DATA_W | Converter result |
| irq_done | output | 1 | Result-ready interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |

## Verification
The bench builds the block with its default 3-bit channel field and 16-bit data. This makes every one of the 64 first/last window pairs small enough to sweep one-shot. For each pair, the bench computes the expected channel order, the count and the final result from the window bounds. Separate scenarios run the repeating mode past its wrap point without reading, which forces an overrun. They also cover the hardware trigger, the disabled state and setup writes while enabled.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_trig,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_result,
  output logic              irq_done,
  output logic              irq_ovr
);
  localparam int CFG_W = 2*CH_W + 2;
  localparam logic [1:0] A_CTL = 2'd0, A_CFG = 2'd1, A_STS = 2'd2, A_DAT = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_t;
  seq_t st;

  logic en, run, cie, oie, cflag, oflag;
  logic [CFG_W-1:0]  cfg;
  logic [CH_W-1:0]   cur;
  logic [DATA_W-1:0] data;

  wire [CH_W-1:0] ch_first = cfg[CH_W-1:0];
  wire [CH_W-1:0] ch_end   = cfg[2*CH_W-1:CH_W];
  wire            repeat_m = cfg[2*CH_W];
  wire            hw_src   = cfg[2*CH_W+1];
  wire [CH_W-1:0] ch_last  = (ch_end < ch_first) ? ch_first : ch_end;
  wire            last_hit = (cur == ch_last);

  wire ctl_wr  = bus_wr && bus_addr == A_CTL;
  wire cfg_wr  = bus_wr && bus_addr == A_CFG;
  wire sts_wr  = bus_wr && bus_addr == A_STS;
  wire data_rd = bus_rd && bus_addr == A_DAT;
  wire done_ok = (st == S_WAIT) && conv_done;
  wire hw_go   = hw_trig && en && hw_src && !run;

  logic unused_wd;
  assign unused_wd = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; run <= 1'b0; cie <= 1'b0; oie <= 1'b0;
      cfg <= '0; cur <= '0; data <= '0; st <= S_IDLE;
    end else begin
      if (st == S_ISSUE) st <= S_WAIT;
      if (done_ok) begin
        data <= conv_result;
        if (!last_hit) begin
          cur <= cur + 1'b1;
          st  <= S_ISSUE;
        end else if (repeat_m) begin
          cur <= ch_first;
          st  <= S_ISSUE;
        end else begin
          run <= 1'b0;
          st  <= S_IDLE;
        end
      end
      if (hw_go) begin
        run <= 1'b1;
        cur <= ch_first;
        st  <= S_ISSUE;
      end
      if (ctl_wr) begin
        en  <= bus_wdata[0];
        cie <= bus_wdata[4];
        oie <= bus_wdata[5];
        if (!bus_wdata[0] || !bus_wdata[1]) begin
          run <= 1'b0;
          st  <= S_IDLE;
        end else if (!run) begin
          run <= 1'b1;
          cur <= ch_first;
          st  <= S_ISSUE;
        end
      end
      if (cfg_wr && !en) cfg <= bus_wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cflag <= 1'b0;
      oflag <= 1'b0;
    end else begin
      if (done_ok)      cflag <= 1'b1;
      else if (data_rd) cflag <= 1'b0;
      if (done_ok && cflag && !data_rd)  oflag <= 1'b1;
      else if (sts_wr && bus_wdata[1])   oflag <= 1'b0;
    end
  end

  assign conv_start = (st == S_ISSUE);
  assign conv_ch    = cur;
  assign irq_done   = cflag & cie;
  assign irq_ovr    = oflag & oie;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: begin
        bus_rdata[0] = en;  bus_rdata[1] = run;
        bus_rdata[4] = cie; bus_rdata[5] = oie;
      end
      A_CFG: bus_rdata[CFG_W-1:0] = cfg;
      A_STS: begin
        bus_rdata[0] = cflag; bus_rdata[1] = oflag;
      end
      default: bus_rdata = data;
    endcase
  end

  // R6
  run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !run);
  // R2
  start_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n) conv_start |-> run);
  // R8
  flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done_ok |=> cflag);
  // R9
  ovr_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok && cflag && !data_rd |=> oflag);
  // R4
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok && last_hit && !repeat_m && !ctl_wr |=> !run && !conv_start);
  // R11
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n) en |=> $stable(cfg));
  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n) !cie |-> !irq_done);
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, hw_trig = 0, conv_done = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata, conv_result = 0;
  logic conv_start, irq_done, irq_ovr;
  logic [2:0] conv_ch;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (.*);

  logic [2:0] chlog [256];
  int nlog = 0, seqn = 0, ctr = 0;
  logic busy = 0;
  logic [2:0] ch_q = 0;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      busy <= 1'b1; ctr <= 3; ch_q <= conv_ch;
      chlog[nlog % 256] <= conv_ch;
      nlog <= nlog + 1;
    end else if (busy) begin
      if (ctr == 1) begin
        busy <= 1'b0; conv_done <= 1'b1;
        conv_result <= 16'h5000 | (16'(ch_q) << 8) | 16'(seqn[7:0]);
        seqn <= seqn + 1;
      end else ctr <= ctr - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int k = 0; k < 300; k++) begin
      rd(2'd0, v);
      if (!v[1]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v, expd;
    int base;
    bit ok;
    repeat (3) @(negedge clk);
    chk(!irq_done && !irq_ovr && !conv_start, "R1 outputs", {irq_done, irq_ovr, conv_start}, 0);
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 reg reset", v, 0);
    end
    wr(2'd0, 16'h00FF);
    rd(2'd0, v);
    chk(v == 16'h0033, "R1 reserved bits", v, 16'h0033);
    wr(2'd0, 16'h0000);

    // R3 R4 R8: sweep every window in one-shot mode
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 8; e++) begin
        int n, last;
        n = (s > e) ? 1 : e - s + 1;
        last = (s > e) ? s : e;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'((e << 3) | s));
        wr(2'd0, 16'h0001);
        base = nlog;
        wr(2'd0, 16'h0003);
        rd(2'd0, v);
        chk(v[1] == 1'b1, "R2 run reads 1", v, 3);
        wait_idle();
        repeat (8) @(negedge clk);
        chk(nlog - base == n, "R4 conversion count", nlog - base, n);
        ok = 1;
        for (int k = 0; k < n; k++)
          if (chlog[(base + k) % 256] != 3'(s + k)) ok = 0;
        chk(ok, "R3 channel order", chlog[base % 256], s);
        rd(2'd0, v);
        chk(v == 16'h0001, "R4 run cleared", v, 1);
        expd = 16'h5000 | 16'(last << 8) | 16'((seqn - 1) & 8'hFF);
        rd(2'd3, v);
        chk(v == expd, "R8 result latched", v, expd);
        rd(2'd2, v);
        chk(v[0] == 1'b0, "R8 read clears flag", v, 0);
        rd(2'd2, v);
        if (v[1]) wr(2'd2, 16'h0002);
      end
    end

    // R7 hardware trigger
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h00AD);
    wr(2'd0, 16'h0001);
    base = nlog;
    @(negedge clk); hw_trig = 1;
    @(negedge clk); hw_trig = 0;
    rd(2'd0, v);
    chk(v == 16'h0003, "R7 hw sets run", v, 3);
    wait_idle();
    repeat (8) @(negedge clk);
    chk(nlog - base == 1 && chlog[base % 256] == 3'd5, "R7 hw pass", nlog - base, 1);
    rd(2'd3, v);

    // R11 setup locked while enabled
    wr(2'd1, 16'h0000);
    rd(2'd1, v);
    chk(v == 16'h00AD, "R11 setup unchanged", v, 16'h00AD);

    // R6 disabled ignores triggers
    wr(2'd0, 16'h0000);
    base = nlog;
    @(negedge clk); hw_trig = 1;
    @(negedge clk); hw_trig = 0;
    wr(2'd0, 16'h0002);
    repeat (10) @(negedge clk);
    rd(2'd0, v);
    chk(v == 0, "R6 run held low", v, 0);
    chk(nlog == base, "R6 no conversion", nlog - base, 0);

    // R5 R9 R10 repeating mode with overrun
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h005A);
    wr(2'd0, 16'h0031);
    base = nlog;
    wr(2'd0, 16'h0033);
    while (nlog - base < 3) @(negedge clk);
    while (!conv_done) @(negedge clk);
    expd = conv_result;
    wr(2'd0, 16'h0031);
    repeat (10) @(negedge clk);
    chk(chlog[base % 256] == 2 && chlog[(base + 1) % 256] == 3 && chlog[(base + 2) % 256] == 2,
        "R5 wrap order", chlog[(base + 2) % 256], 2);
    rd(2'd0, v);
    chk(v == 16'h0031, "R5 stopped by software", v, 16'h0031);
    chk(irq_done && irq_ovr, "R10 both irqs", {irq_done, irq_ovr}, 3);
    wr(2'd0, 16'h0001);
    chk(!irq_done && !irq_ovr, "R10 irqs masked", {irq_done, irq_ovr}, 0);
    rd(2'd2, v);
    chk(v == 16'h0003, "R9 both flags", v, 3);
    wr(2'd0, 16'h0031);
    rd(2'd3, v);
    chk(v == expd, "R9 data overwritten", v, expd);
    @(negedge clk);
    chk(!irq_done && irq_ovr, "R8 irq_done drops after read", {irq_done, irq_ovr}, 1);
    rd(2'd2, v);
    chk(v == 16'h0002, "R9 overrun sticky", v, 2);
    wr(2'd2, 16'h0002);
    rd(2'd2, v);
    chk(v == 0 && !irq_ovr, "R9 overrun cleared", v, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule